// File: doc/BRIEF.md
# Four-Stage Pipelined Floating-Point Adder

The block adds two positive floating-point numbers, each made of an unsigned fraction and a signed base-2 exponent. The value of an operand is `frac / 2^FRAC_W * 2^exp`. A normalized fraction has its top bit set, which places it in the range 0.5 up to 1. The work is split over four register-separated stages:

- Stage 1 compares the exponents, keeps the larger one and aligns the other operand's fraction by shifting it right.
- Stage 2 adds the two aligned fractions with one spare carry bit.
- Stage 3 renormalizes the sum: right by one place on a carry, or left by its leading-zero count.
- Stage 4 corrects the exponent to match the shift.

Operands enter through a valid/ready stream and results leave through a second valid/ready stream. The pipeline has a single global advance. It moves whenever the output register is empty or the consumer takes the result.

Back-pressure rules:

- When the consumer holds `out_ready` low while a result is presented, every stage freezes. `in_ready` drops in that same cycle.
- A producer may hold `in_valid` with stable data for as long as it likes. A transfer happens only on a cycle with both `in_valid` and `in_ready` high.
- No pair is dropped, duplicated or reordered.

Bits shifted out during alignment are truncated. Rounding, special values and flags are not provided.

Top module: `fpadd4_pipe`

## Requirements
- R1: While reset is asserted, and right after it is released, `out_valid` is low and `in_ready` is high.
- R2: A pair accepted while `out_ready` stays high shows up with `out_valid` exactly four clock cycles after the accepting edge. A new pair can be accepted on every cycle.
- R3: Fractions are FRAC_W-bit unsigned values with the binary point above the MSB. Exponents are EXP_W-bit two's complement. The result uses the larger exponent, and the other fraction is shifted right by the exponent difference before the add, with the lost low bits truncated.
- R4: When the exponent difference is FRAC_W or more, the smaller operand contributes zero. The result then equals the larger operand (for a normalized larger operand).
- R5: When the fraction sum is 1.0 or more (carry out of the MSB), the result fraction is the sum shifted right by one place, with the carry as its new MSB, and the exponent is the larger exponent plus one.
- R6: When the fraction sum is nonzero and below 0.5, it is shifted left by its leading-zero count and the exponent is reduced by that count.
- R7: A zero fraction sum gives a zero fraction and a zero exponent, whatever the input exponents are.
- R8: Every presented result has its fraction MSB set unless the fraction is zero.
- R9: While `out_valid` is high and `out_ready` is low, the output holds steady and `in_ready` is low. Pairs come out in the order they were accepted, with no loss and no duplication.
- R10: Exponent arithmetic wraps modulo 2^EXP_W. For example, a carry at exponent 127 gives -128 with the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Pipeline can take a pair this cycle |
| in_frac_a | input | FRAC_W | Fraction of operand A |
| in_exp_a | input | EXP_W | Exponent of operand A, two's complement |
| in_frac_b | input | FRAC_W | Fraction of operand B |
| in_exp_b | input | EXP_W | Exponent of operand B, two's complement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_frac | output | FRAC_W | Normalized result fraction |
| out_exp | output | EXP_W | Result exponent |

## Verification
Each result is due four rising edges after the edge that accepted its pair, as long as `out_ready` stays high. A stall adds exactly the number of cycles in which the output is held.

The bench computes the expected pair when the transfer happens and queues it with a cycle stamp. It compares a result on the falling edge before the edge that consumes it. The stamp difference must be four in the stall-free scenarios.

Inputs change one nanosecond after a rising edge, and all sampling happens on falling edges, so no check races the pipeline registers.

// File: rtl/fpadd4_pkg.sv
package fpadd4_pkg;

  localparam int PIPE_DEPTH = 4;

  // What the normalizer did to the raw sum
  typedef enum logic [1:0] {
    NRM_ZERO  = 2'd0,  // sum was zero
    NRM_RIGHT = 2'd1,  // carry out: shifted right by one
    NRM_LEFT  = 2'd2   // shifted left by a leading-zero count (may be 0)
  } nrm_act_e;

endpackage

// File: rtl/fpa_align.sv
module fpa_align #(
  parameter int FW = 16,
  parameter int EW = 8
) (
  input  logic [FW-1:0] frac_a,
  input  logic [EW-1:0] exp_a,
  input  logic [FW-1:0] frac_b,
  input  logic [EW-1:0] exp_b,
  output logic [EW-1:0] big_exp,
  output logic [FW-1:0] big_frac,
  output logic [FW-1:0] small_aligned
);

  logic signed [EW:0] dif;
  logic [EW:0]        mag;
  logic               a_wins;
  logic [FW-1:0]      small_raw;

  always_comb begin
    dif       = $signed({exp_a[EW-1], exp_a}) - $signed({exp_b[EW-1], exp_b});
    a_wins    = ~dif[EW];
    mag       = a_wins ? $unsigned(dif) : $unsigned(~dif + 1'b1);
    big_exp   = a_wins ? exp_a  : exp_b;
    big_frac  = a_wins ? frac_a : frac_b;
    small_raw = a_wins ? frac_b : frac_a;
    if (mag >= (EW+1)'(FW))
      small_aligned = '0;
    else
      small_aligned = small_raw >> mag;
  end

endmodule

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
  parameter int W  = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros,
  output logic          all_zero
);

  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
    all_zero = (vec == '0);
  end

endmodule

// File: rtl/fpa_norm.sv
module fpa_norm
  import fpadd4_pkg::*;
#(
  parameter int FW = 16,
  localparam int LW = $clog2(FW + 1)
) (
  input  logic [FW:0]   sum,
  output logic [FW-1:0] frac,
  output logic [LW-1:0] shift_cnt,
  output nrm_act_e      act
);

  logic [LW-1:0] lz;
  logic          lo_zero;

  fpa_lzc #(.W(FW)) u_lzc (
    .vec      (sum[FW-1:0]),
    .zeros    (lz),
    .all_zero (lo_zero)
  );

  always_comb begin
    if (sum[FW]) begin
      frac      = sum[FW:1];
      shift_cnt = '0;
      act       = NRM_RIGHT;
    end else if (lo_zero) begin
      frac      = '0;
      shift_cnt = '0;
      act       = NRM_ZERO;
    end else begin
      frac      = sum[FW-1:0] << lz;
      shift_cnt = lz;
      act       = NRM_LEFT;
    end
  end

endmodule

// File: rtl/fpadd4_pipe.sv
module fpadd4_pipe
  import fpadd4_pkg::*;
#(
  parameter int FRAC_W = 16,
  parameter int EXP_W  = 8,
  localparam int LW    = $clog2(FRAC_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FRAC_W-1:0] in_frac_a,
  input  logic [EXP_W-1:0]  in_exp_a,
  input  logic [FRAC_W-1:0] in_frac_b,
  input  logic [EXP_W-1:0]  in_exp_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FRAC_W-1:0] out_frac,
  output logic [EXP_W-1:0]  out_exp
);

  logic [PIPE_DEPTH-1:0] vld_q;
  logic                  advance;

  // Global advance: move when the last stage is empty or being drained
  assign advance  = ~vld_q[PIPE_DEPTH-1] | out_ready;
  assign in_ready = advance;

  always_ff @(posedge clk) begin
    if (!rst_n)       vld_q <= '0;
    else if (advance) vld_q <= {vld_q[PIPE_DEPTH-2:0], in_valid};
  end

  // ---------------- Stage 1: compare and align ----------------
  logic [EXP_W-1:0]  s1_exp_d, s1_exp_q;
  logic [FRAC_W-1:0] s1_big_d, s1_big_q, s1_sml_d, s1_sml_q;

  fpa_align #(.FW(FRAC_W), .EW(EXP_W)) u_align (
    .frac_a        (in_frac_a),
    .exp_a         (in_exp_a),
    .frac_b        (in_frac_b),
    .exp_b         (in_exp_b),
    .big_exp       (s1_exp_d),
    .big_frac      (s1_big_d),
    .small_aligned (s1_sml_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_exp_q <= '0;
      s1_big_q <= '0;
      s1_sml_q <= '0;
    end else if (advance) begin
      s1_exp_q <= s1_exp_d;
      s1_big_q <= s1_big_d;
      s1_sml_q <= s1_sml_d;
    end
  end

  // ---------------- Stage 2: fixed-point add ----------------
  logic [EXP_W-1:0] s2_exp_q;
  logic [FRAC_W:0]  s2_sum_d, s2_sum_q;

  assign s2_sum_d = {1'b0, s1_big_q} + {1'b0, s1_sml_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_exp_q <= '0;
      s2_sum_q <= '0;
    end else if (advance) begin
      s2_exp_q <= s1_exp_q;
      s2_sum_q <= s2_sum_d;
    end
  end

  // ---------------- Stage 3: normalize ----------------
  logic [FRAC_W-1:0] s3_frac_d, s3_frac_q;
  logic [LW-1:0]     s3_cnt_d, s3_cnt_q;
  nrm_act_e          s3_act_d, s3_act_q;
  logic [EXP_W-1:0]  s3_exp_q;

  fpa_norm #(.FW(FRAC_W)) u_norm (
    .sum       (s2_sum_q),
    .frac      (s3_frac_d),
    .shift_cnt (s3_cnt_d),
    .act       (s3_act_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s3_frac_q <= '0;
      s3_cnt_q  <= '0;
      s3_act_q  <= NRM_ZERO;
      s3_exp_q  <= '0;
    end else if (advance) begin
      s3_frac_q <= s3_frac_d;
      s3_cnt_q  <= s3_cnt_d;
      s3_act_q  <= s3_act_d;
      s3_exp_q  <= s2_exp_q;
    end
  end

  // ---------------- Stage 4: exponent correction ----------------
  logic [EXP_W-1:0]  s4_exp_d, s4_exp_q;
  logic [FRAC_W-1:0] s4_frac_q;

  always_comb begin
    unique case (s3_act_q)
      NRM_RIGHT: s4_exp_d = s3_exp_q + EXP_W'(1);
      NRM_LEFT:  s4_exp_d = s3_exp_q - EXP_W'(s3_cnt_q);
      default:   s4_exp_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s4_exp_q  <= '0;
      s4_frac_q <= '0;
    end else if (advance) begin
      s4_exp_q  <= s4_exp_d;
      s4_frac_q <= s3_frac_q;
    end
  end

  assign out_valid = vld_q[PIPE_DEPTH-1];
  assign out_frac  = s4_frac_q;
  assign out_exp   = s4_exp_q;

endmodule

// File: rtl/fpadd4_chk.sv
module fpadd4_chk #(
  parameter int FRAC_W = 16,
  parameter int EXP_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FRAC_W-1:0] out_frac,
  input logic [EXP_W-1:0]  out_exp
);

  logic [3:0] occ;
  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + 4'((in_valid && in_ready) ? 1 : 0)
                    - 4'((out_valid && out_ready) ? 1 : 0);
  end

  // R8
  norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_frac[FRAC_W-1] || out_frac == '0));

  // R7
  zero_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_frac == '0) |-> out_exp == '0);

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_frac) && $stable(out_exp)));

  // R9
  stall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R2
  latency_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 4) && $past(out_ready, 1) && $past(out_ready, 2)
     && $past(out_ready, 3)) |-> out_valid);

  // R9
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 4'd4);

endmodule

bind fpadd4_pipe fpadd4_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_frac  (out_frac),
  .out_exp   (out_exp)
);

// File: tb/fpadd4_pipe_test.sv
`timescale 1ns/1ps
module fpadd4_pipe_test;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [15:0] in_frac_a = 0, in_frac_b = 0;
  logic [7:0]  in_exp_a = 0, in_exp_b = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [15:0] out_frac;
  logic [7:0]  out_exp;

  int checks = 0, errors = 0;
  int cyc = 0;
  int accepted = 0, delivered = 0;
  bit lat_on = 0;
  bit done = 0;
  logic [23:0] exp_q[$];
  int          stamp_q[$];
  string       tag_q[$];
  string       cur_tag = "R3";

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fpadd4_pipe uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_frac_a(in_frac_a), .in_exp_a(in_exp_a),
    .in_frac_b(in_frac_b), .in_exp_b(in_exp_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_frac(out_frac), .out_exp(out_exp)
  );

  function automatic logic [23:0] model(input logic [15:0] fa, input logic [7:0] ea,
                                        input logic [15:0] fb, input logic [7:0] eb);
    int d, t, lz;
    logic [15:0] big, sm, al;
    logic [7:0]  r;
    logic [16:0] s;
    d = int'($signed(ea)) - int'($signed(eb));
    if (d >= 0) begin r = ea; big = fa; sm = fb; t = d; end
    else        begin r = eb; big = fb; sm = fa; t = -d; end
    al = (t >= 16) ? 16'h0 : (sm >> t);
    s = {1'b0, big} + {1'b0, al};
    if (s == 17'h0) return 24'h0;
    if (s[16]) return {s[16:1], r + 8'd1};
    lz = 0;
    while (!s[15]) begin s = s << 1; lz++; end
    return {s[15:0], r - 8'(lz)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv,
                       input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Monitor: samples on falling edges, away from the active edge
  always @(negedge clk) begin
    if (rst_n && in_valid && in_ready) begin
      exp_q.push_back(model(in_frac_a, in_exp_a, in_frac_b, in_exp_b));
      stamp_q.push_back(cyc);
      tag_q.push_back(cur_tag);
      accepted++;
    end
    if (rst_n && out_valid && out_ready) begin
      delivered++;
      if (exp_q.size() == 0) begin
        check("R9", 1, 0, "unexpected result");
      end else begin
        logic [23:0] e;
        int st;
        string tg;
        e = exp_q.pop_front();
        st = stamp_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, {8'h0, out_frac, out_exp}, {8'h0, e}, "result {frac,exp}");
        check("R8", 32'(out_frac[15] || out_frac == 16'h0), 1, "msb set");
        if (lat_on) check("R2", 32'(cyc - st), 4, "latency");
      end
    end
  end

  task automatic send(input logic [15:0] fa, input logic [7:0] ea,
                      input logic [15:0] fb, input logic [7:0] eb);
    in_frac_a = fa; in_exp_a = ea; in_frac_b = fb; in_exp_b = eb;
    in_valid = 1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    check("R9", 32'(exp_q.size()), 0, "all results delivered");
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 32'(out_valid), 0, "out_valid in reset");
    check("R1", 32'(in_ready), 1, "in_ready in reset");
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check("R1", 32'(out_valid), 0, "out_valid after reset");
    check("R1", 32'(in_ready), 1, "in_ready after reset");
    @(posedge clk); #1;
  endtask

  task automatic t_align();
    cur_tag = "R3"; lat_on = 1;
    send(16'hC000, 8'd3, 16'h8000, 8'd2);
    send(16'h8000, 8'd1, 16'hF0F3, 8'd4);
    send(16'hAAAA, 8'hFE, 16'hFFFF, 8'hF7);
    send(16'h9001, 8'd10, 16'h8001, 8'd3);
    drain();
  endtask

  task automatic t_far();
    cur_tag = "R4";
    send(16'hB000, 8'd20, 16'hFFFF, 8'd4);
    send(16'hFFFF, 8'hE0, 16'h8123, 8'd0);
    send(16'h8001, 8'd50, 16'hFFFF, 8'd35);
    drain();
  endtask

  task automatic t_carry();
    cur_tag = "R5";
    send(16'h8000, 8'd3, 16'h8000, 8'd3);
    send(16'hFFFF, 8'hF0, 16'hFFFF, 8'hF0);
    send(16'hC001, 8'd0, 16'hC000, 8'd0);
    drain();
  endtask

  task automatic t_left();
    cur_tag = "R6";
    send(16'h2000, 8'd5, 16'h1000, 8'd5);
    send(16'h0001, 8'd0, 16'h0000, 8'd0);
    send(16'h0300, 8'd2, 16'h0040, 8'd0);
    drain();
  endtask

  task automatic t_zero();
    cur_tag = "R7";
    send(16'h0000, 8'd5, 16'h0000, 8'hFD);
    send(16'h0000, 8'h7F, 16'h0001, 8'd100);
    drain();
  endtask

  task automatic t_wrap();
    cur_tag = "R10";
    send(16'h8000, 8'd127, 16'h8000, 8'd127);
    send(16'h0001, 8'h88, 16'h0000, 8'h88);
    drain();
  endtask

  task automatic t_stream();
    int low_seen = 0;
    cur_tag = "R2"; lat_on = 1;
    in_valid = 1;
    for (int i = 0; i < 8; i++) begin
      in_frac_a = 16'h8000 | 16'(i * 977);
      in_exp_a  = 8'(i);
      in_frac_b = 16'hFFFF - 16'(i * 311);
      in_exp_b  = 8'(3 - i);
      @(negedge clk);
      if (!in_ready) low_seen++;
      @(posedge clk); #1;
    end
    in_valid = 0;
    check("R2", 32'(low_seen), 0, "in_ready stayed high");
    drain();
  endtask

  task automatic t_backpressure();
    logic [23:0] held;
    int acc0;
    cur_tag = "R9"; lat_on = 0;
    acc0 = accepted;
    out_ready = 0;
    for (int i = 0; i < 4; i++) send(16'h8000 + 16'(i * 4096), 8'(i), 16'hA000, 8'd1);
    in_frac_a = 16'hEEEE; in_exp_a = 8'd9; in_frac_b = 16'h9999; in_exp_b = 8'd9;
    in_valid = 1;
    @(negedge clk);
    check("R9", 32'(in_ready), 0, "in_ready low while output blocked");
    check("R9", 32'(out_valid), 1, "out_valid while blocked");
    held = {out_frac, out_exp};
    repeat (5) @(negedge clk);
    check("R9", {8'h0, out_frac, out_exp}, {8'h0, held}, "output held");
    check("R9", 32'(accepted - acc0), 4, "accepted while blocked");
    @(posedge clk); #1;
    out_ready = 1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0;
    drain();
    check("R9", 32'(accepted - delivered), 0, "no loss or duplicate");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL R2 watchdog: actual=hung expected=completed");
    finish_run();
  end

  initial begin
    t_reset();
    t_align();
    t_far();
    t_carry();
    t_left();
    t_zero();
    t_wrap();
    t_stream();
    t_backpressure();
    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule